// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit keeps two 16-bit data pointers for an 8051-style core, a primary one and an auxiliary one, plus a control byte. The control byte picks which pointer is active and sets a step direction for each pointer. It can also make the active pointer step by itself after memory accesses, and it can make the choice of pointer flip after each pointer instruction. The active pointer value is driven out every cycle for address generation.

Software reaches the four pointer bytes and the control byte through a byte-wide special-function-register port. Writes take effect at the next clock edge, and reads are combinational. The instruction decoder gives one-cycle strobes for five events: pointer increment, 16-bit immediate load, code read at accumulator plus pointer, external read, and external write.

The unit has no data stream, so it has no valid/ready handshake. Every strobe is taken in the cycle it is high, and there is no back-pressure. The decoder raises at most one event strobe in any cycle.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset both pointers read 0000h, `ptr_out` is 0000h and the control byte at 86h reads 04h.
- R2: Control bit 0 selects the active pointer: 0 for the primary pointer, 1 for the auxiliary pointer. `ptr_out` shows the active pointer. The primary pointer bytes read at 82h (low) and 83h (high), and the auxiliary bytes read at 84h (low) and 85h (high).
- R3: An SFR write to a pointer byte changes only that byte. It never steps a pointer and never changes the selection.
- R4: An increment event adds one to the active pointer when that pointer's direction bit is 0, and subtracts one when it is 1. Bit 6 is the direction bit for the primary pointer and bit 7 is the direction bit for the auxiliary pointer.
- R5: A load event writes all 16 bits of the active pointer from `load_val` in one cycle and leaves the other pointer unchanged.
- R6: When control bit 4 is 1, a code read, external read or external write steps the active pointer in its direction. When bit 4 is 0, these events leave both pointers unchanged. Increment and load events are never auto-stepped.
- R7: When control bit 5 is 1, each of the five events inverts the selection bit. When bit 5 is 0, no event changes the selection.
- R8: An event acts on the pointer chosen before the event. A toggle caused by that event only takes effect for the next cycle.
- R9: Stepping wraps modulo 2^16: FFFFh plus one gives 0000h, and 0000h minus one gives FFFFh.
- R10: Control bits 3 to 1 always read 010b, whatever is written to them. Bits 7 to 4 and bit 0 read back as written.
- R11: When a decoder event and an SFR write land on the same pointer, or on the selection bit, in the same cycle, the event's result wins.
- R12: At most one event strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr`, or 00h if the address is not one of the unit's |
| ev_inc | input | 1 | Increment-pointer event |
| ev_load | input | 1 | Load-immediate event |
| load_val | input | 16 | Immediate value for the load event |
| ev_code_rd | input | 1 | Code read at accumulator plus pointer |
| ev_ext_rd | input | 1 | External read through the pointer |
| ev_ext_wr | input | 1 | External write through the pointer |
| ptr_out | output | 16 | Active pointer value |

## Verification
Increments are run with each direction bit in both states and on both pointers, and the other pointer is checked each time. This separates a swapped direction-bit mapping from a wrong step sign. Values at FFFFh and 0000h expose any missing wrap.

The three memory events are issued with auto-step on and off, and an increment is issued with auto-step on. This tells apart stepping that is correctly gated from stepping that happens twice or never. All five events are toggled with the toggle bit set and cleared. A load is issued while toggling, to show that the pre-event selection is the one used.

Same-cycle collisions of an SFR write with an event show which of the two wins.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NPTR   = 2;

  localparam logic [7:0] ADDR_P0_LO = 8'h82;
  localparam logic [7:0] ADDR_P0_HI = 8'h83;
  localparam logic [7:0] ADDR_P1_LO = 8'h84;
  localparam logic [7:0] ADDR_P1_HI = 8'h85;
  localparam logic [7:0] ADDR_CTL   = 8'h86;

  localparam logic [2:0] CTL_FIXED = 3'b010;

  typedef struct packed {
    logic [NPTR-1:0] dir;
    logic            tgl_en;
    logic            auto_en;
    logic            sel;
  } ctl_t;

  function automatic logic [7:0] lo_addr(input int idx);
    return (idx == 0) ? ADDR_P0_LO : ADDR_P1_LO;
  endfunction

  function automatic logic [7:0] hi_addr(input int idx);
    return (idx == 0) ? ADDR_P0_HI : ADDR_P1_HI;
  endfunction
endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] wdata,
  input  logic       any_ev,
  output ctl_t       ctl,
  output logic [7:0] rd_byte
);
  ctl_t ctl_q;
  logic sel_n;

  always_comb begin
    sel_n = ctl_q.sel;
    if (ctl_we) sel_n = wdata[0];
    if (any_ev && ctl_q.tgl_en) sel_n = ~ctl_q.sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.dir     <= wdata[7:6];
        ctl_q.tgl_en  <= wdata[5];
        ctl_q.auto_en <= wdata[4];
      end
      ctl_q.sel <= sel_n;
    end
  end

  assign ctl     = ctl_q;
  assign rd_byte = {ctl_q.dir, ctl_q.tgl_en, ctl_q.auto_en, CTL_FIXED, ctl_q.sel};

  // R7, R11: an event with toggle enabled flips the pre-event selection
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ev && ctl_q.tgl_en) |=> (ctl_q.sel != $past(ctl_q.sel)));

  // R3, R7: no control write and no toggling event keep the selection
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !(any_ev && ctl_q.tgl_en)) |=> $stable(ctl_q.sel));
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  input  logic             dir,
  output logic [PTR_W-1:0] value
);
  logic [PTR_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load) begin
      val_q <= load_val;
    end else if (step) begin
      val_q <= dir ? val_q - 1'b1 : val_q + 1'b1;
    end else begin
      if (we_lo) val_q[BYTE_W-1:0]     <= wbyte;
      if (we_hi) val_q[PTR_W-1:BYTE_W] <= wbyte;
    end
  end

  assign value = val_q;

  // R5, R11: a load lands all 16 bits and beats any byte write
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val_q == $past(load_val)));

  // R9: an up step wraps modulo 2^16
  p_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !dir) |=> (val_q == PTR_W'($past(val_q) + 1'b1)));

  // R3: no write, load or step keeps the value
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step && !we_lo && !we_hi) |=> $stable(val_q));
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dptr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        ev_inc,
  input  logic        ev_load,
  input  logic [15:0] load_val,
  input  logic        ev_code_rd,
  input  logic        ev_ext_rd,
  input  logic        ev_ext_wr,
  output logic [15:0] ptr_out
);
  ctl_t             ctl;
  logic [7:0]       ctl_rd;
  logic             acc_ev;
  logic             any_ev;
  logic [PTR_W-1:0] ptr_val [NPTR];

  assign acc_ev = ev_code_rd | ev_ext_rd | ev_ext_wr;
  assign any_ev = acc_ev | ev_inc | ev_load;

  dptr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (sfr_wr && (sfr_addr == ADDR_CTL)),
    .wdata   (sfr_wdata),
    .any_ev  (any_ev),
    .ctl     (ctl),
    .rd_byte (ctl_rd)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic hit;
    assign hit = (ctl.sel == 1'(g));
    dptr_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_lo    (sfr_wr && (sfr_addr == lo_addr(g))),
      .we_hi    (sfr_wr && (sfr_addr == hi_addr(g))),
      .wbyte    (sfr_wdata),
      .load     (hit && ev_load),
      .load_val (load_val),
      .step     (hit && (ev_inc || (ctl.auto_en && acc_ev))),
      .dir      (ctl.dir[g]),
      .value    (ptr_val[g])
    );
  end

  assign ptr_out = ptr_val[ctl.sel];

  always_comb begin
    unique case (sfr_addr)
      ADDR_P0_LO: sfr_rdata = ptr_val[0][BYTE_W-1:0];
      ADDR_P0_HI: sfr_rdata = ptr_val[0][PTR_W-1:BYTE_W];
      ADDR_P1_LO: sfr_rdata = ptr_val[1][BYTE_W-1:0];
      ADDR_P1_HI: sfr_rdata = ptr_val[1][PTR_W-1:BYTE_W];
      ADDR_CTL:   sfr_rdata = ctl_rd;
      default:    sfr_rdata = 8'h00;
    endcase
  end

  // R12: the decoder raises at most one event at a time
  p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_inc, ev_load, ev_code_rd, ev_ext_rd, ev_ext_wr}));

  // R8: a load shows up on the output only if no toggle moved the selection
  p_load_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !ctl.tgl_en && !sfr_wr) |=> (ptr_out == $past(load_val)));
endmodule

// File: tb/dptr_pair_unit_bench.sv
module dptr_pair_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ev_inc = 1'b0, ev_load = 1'b0, ev_code_rd = 1'b0;
  logic        ev_ext_rd = 1'b0, ev_ext_wr = 1'b0;
  logic [15:0] load_val = 16'h0000;
  logic [15:0] ptr_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam int EV_INC = 0, EV_LOAD = 1, EV_CODE = 2, EV_XRD = 3, EV_XWR = 4, EV_NONE = 5;

  always #2 clk = ~clk;

  dptr_pair_unit u_dptr_pair_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ev_inc(ev_inc),
    .ev_load(ev_load), .load_val(load_val), .ev_code_rd(ev_code_rd),
    .ev_ext_rd(ev_ext_rd), .ev_ext_wr(ev_ext_wr), .ptr_out(ptr_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: optional SFR write plus optional event
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     input int ev, input logic [15:0] lv);
    @(negedge clk);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d; load_val = lv;
    ev_inc = (ev == EV_INC); ev_load = (ev == EV_LOAD); ev_code_rd = (ev == EV_CODE);
    ev_ext_rd = (ev == EV_XRD); ev_ext_wr = (ev == EV_XWR);
    @(negedge clk);
    sfr_wr = 1'b0; ev_inc = 1'b0; ev_load = 1'b0; ev_code_rd = 1'b0;
    ev_ext_rd = 1'b0; ev_ext_wr = 1'b0;
  endtask

  task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, EV_NONE, 16'h0);
  endtask

  task automatic ev(input int e, input logic [15:0] lv);
    cyc(1'b0, 8'h00, 8'h00, e, lv);
  endtask

  task automatic rd_sfr(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic rd_ptr(input int idx, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_sfr(idx == 0 ? 8'h82 : 8'h84, lo);
    rd_sfr(idx == 0 ? 8'h83 : 8'h85, hi);
    v = {hi, lo};
  endtask

  task automatic set_ptr(input int idx, input logic [15:0] v);
    wr_sfr(idx == 0 ? 8'h82 : 8'h84, v[7:0]);
    wr_sfr(idx == 0 ? 8'h83 : 8'h85, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] c; logic [15:0] p;
    rd_sfr(8'h86, c); chk("R1 ctl", {8'h0, c}, 16'h0004);
    rd_ptr(0, p); chk("R1 p0", p, 16'h0000);
    rd_ptr(1, p); chk("R1 p1", p, 16'h0000);
    chk("R1 out", ptr_out, 16'h0000);
  endtask

  task automatic t_sfr_bytes;
    logic [7:0] c; logic [15:0] p;
    wr_sfr(8'h86, 8'h20);
    set_ptr(0, 16'h1234); set_ptr(1, 16'hABCD);
    rd_ptr(0, p); chk("R2 p0 bytes", p, 16'h1234);
    rd_ptr(1, p); chk("R2 p1 bytes", p, 16'hABCD);
    rd_sfr(8'h86, c); chk("R3 no toggle on byte write", {8'h0, c}, 16'h0024);
    chk("R2 out sel0", ptr_out, 16'h1234);
    wr_sfr(8'h82, 8'h99);
    rd_ptr(0, p); chk("R3 low byte only", p, 16'h1299);
    wr_sfr(8'h82, 8'h34);
    wr_sfr(8'h86, 8'h01);
    chk("R2 out sel1", ptr_out, 16'hABCD);
  endtask

  task automatic t_inc;
    logic [15:0] p;
    wr_sfr(8'h86, 8'h00); ev(EV_INC, 0);
    rd_ptr(0, p); chk("R4 p0 up", p, 16'h1235);
    rd_ptr(1, p); chk("R4 p1 untouched", p, 16'hABCD);
    wr_sfr(8'h86, 8'h40); ev(EV_INC, 0);
    rd_ptr(0, p); chk("R4 p0 down bit6", p, 16'h1234);
    wr_sfr(8'h86, 8'h41); ev(EV_INC, 0);
    rd_ptr(1, p); chk("R4 p1 up bit7=0", p, 16'hABCE);
    wr_sfr(8'h86, 8'h81); ev(EV_INC, 0);
    rd_ptr(1, p); chk("R4 p1 down bit7", p, 16'hABCD);
    rd_ptr(0, p); chk("R4 p0 untouched", p, 16'h1234);
  endtask

  task automatic t_wrap;
    logic [15:0] p;
    set_ptr(0, 16'hFFFF); wr_sfr(8'h86, 8'h00); ev(EV_INC, 0);
    rd_ptr(0, p); chk("R9 up wrap", p, 16'h0000);
    set_ptr(1, 16'h0000); wr_sfr(8'h86, 8'h81); ev(EV_INC, 0);
    rd_ptr(1, p); chk("R9 down wrap", p, 16'hFFFF);
  endtask

  task automatic t_load;
    logic [15:0] p;
    set_ptr(0, 16'h1234); wr_sfr(8'h86, 8'h01);
    ev(EV_LOAD, 16'h5A5A);
    rd_ptr(1, p); chk("R5 p1 loaded", p, 16'h5A5A);
    rd_ptr(0, p); chk("R5 p0 untouched", p, 16'h1234);
    chk("R5 out", ptr_out, 16'h5A5A);
  endtask

  task automatic t_auto;
    logic [15:0] p;
    set_ptr(0, 16'h0100); wr_sfr(8'h86, 8'h10);
    ev(EV_CODE, 0); rd_ptr(0, p); chk("R6 code rd step", p, 16'h0101);
    ev(EV_XRD, 0);  rd_ptr(0, p); chk("R6 ext rd step", p, 16'h0102);
    ev(EV_XWR, 0);  rd_ptr(0, p); chk("R6 ext wr step", p, 16'h0103);
    ev(EV_INC, 0);  rd_ptr(0, p); chk("R6 inc single step", p, 16'h0104);
    ev(EV_LOAD, 16'h0200); rd_ptr(0, p); chk("R6 load no step", p, 16'h0200);
    wr_sfr(8'h86, 8'h50);
    ev(EV_XRD, 0);  rd_ptr(0, p); chk("R6 auto down", p, 16'h01FF);
    wr_sfr(8'h86, 8'h00);
    ev(EV_CODE, 0); ev(EV_XRD, 0); ev(EV_XWR, 0);
    rd_ptr(0, p); chk("R6 auto off", p, 16'h01FF);
  endtask

  task automatic t_toggle;
    logic [7:0] c; logic [15:0] p;
    wr_sfr(8'h86, 8'h20);
    for (int e = EV_INC; e <= EV_XWR; e++) begin
      ev(e, 16'h1111);
      rd_sfr(8'h86, c);
      chk("R7 toggle", {15'h0, c[0]}, 16'((e + 1) % 2));
    end
    wr_sfr(8'h86, 8'h00);
    ev(EV_INC, 0); ev(EV_XWR, 0);
    rd_sfr(8'h86, c); chk("R7 no toggle", {15'h0, c[0]}, 16'h0000);
    set_ptr(1, 16'h7777); wr_sfr(8'h86, 8'h20);
    ev(EV_LOAD, 16'h2222);
    rd_ptr(0, p); chk("R8 load used old sel", p, 16'h2222);
    chk("R8 out after toggle", ptr_out, 16'h7777);
  endtask

  task automatic t_fixed_bits;
    logic [7:0] c;
    wr_sfr(8'h86, 8'hFF); rd_sfr(8'h86, c); chk("R10 all ones", {8'h0, c}, 16'h00F5);
    wr_sfr(8'h86, 8'h00); rd_sfr(8'h86, c); chk("R10 all zeros", {8'h0, c}, 16'h0004);
  endtask

  task automatic t_collide;
    logic [7:0] c; logic [15:0] p;
    set_ptr(0, 16'h3000); wr_sfr(8'h86, 8'h00);
    cyc(1'b1, 8'h82, 8'h77, EV_INC, 16'h0);
    rd_ptr(0, p); chk("R11 inc beats byte write", p, 16'h3001);
    cyc(1'b1, 8'h83, 8'h55, EV_LOAD, 16'h4444);
    rd_ptr(0, p); chk("R11 load beats byte write", p, 16'h4444);
    wr_sfr(8'h86, 8'h20);
    cyc(1'b1, 8'h86, 8'h20, EV_INC, 16'h0);
    rd_sfr(8'h86, c); chk("R11 toggle beats sel write", {15'h0, c[0]}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_sfr_bytes; t_inc; t_wrap; t_load; t_auto; t_toggle;
    t_fixed_bits; t_collide;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule